// File: doc/BRIEF.md
# Capacitor Voltage Tolerance Band Monitor

This block watches the capacitor voltages of one converter arm. Each control period it receives a burst of cell voltage samples, one for each sub-module. It reduces the burst to a mean, a minimum and a maximum. It then decides whether the arm is still inside its tolerance band. When it is not, the out-of-band flag tells the downstream cell selection logic to sort the cells again and to forget the switching states it kept from the previous period.

Two band modes are available. In mean mode, the band is a window of plus or minus a programmable percentage around a nominal voltage. The block also raises a separate flag when the mean drops below the window, because that case forces every module off. In cell mode, the largest sample must stay under an absolute upper limit and the smallest must stay over an absolute lower limit.

A band of zero width can never contain a value, so it flags every period. That setting gives sorting on every period. The percentage is applied as a fixed-point product of the nominal voltage, and the mean uses a fixed reciprocal of the cell count. Neither path needs a divider.

Top module: `tol_band_mon`

## Requirements
- R1: The mean is floor(S * K / 65536), where S is the sum of the period's samples and K = ceil(65536 / N_CELLS), saturated to 2^VW-1. It appears on avg_o in the cycle after the beat that carries last_i. In that same cycle done_o is high for exactly one cycle. Beats with vld_i low inside a period are not counted.
- R2: min_o and max_o are the smallest and largest samples of the latest period only. The tracking restarts with the first beat of every period.
- R3: In mean mode (mode_i = 0), let D = floor(nom_i * pct_i * 655 / 65536). The lower limit L is nom_i - D, or 0 when D >= nom_i. The upper limit H is min(nom_i + D, 2^(VW+1)-1). oob_o is low only when L < mean < H, so a mean that equals either limit counts as out of band.
- R4: A zero-width band flags every period. This covers pct_i = 0 in mean mode, and cell_lo_i >= cell_hi_i in cell mode.
- R5: In cell mode (mode_i = 1), oob_o is low only when cell_lo_i < minimum and maximum < cell_hi_i.
- R6: under_o is high only in mean mode, and only when mean < L. under_o is always low in cell mode, whatever the minimum is.
- R7: mode_i, nom_i, pct_i, cell_lo_i and cell_hi_i are taken on the first beat of a period. Changes to them during the rest of the period have no effect on that period's result.
- R8: avg_o, min_o, max_o, oob_o and under_o hold their values until the next period completes. done_o is never high except in the cycle after a last beat.
- R9: While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Sample on volt_i is valid |
| last_i | input | 1 | Marks the final sample of a period |
| volt_i | input | VW | Cell capacitor voltage sample, unsigned |
| mode_i | input | 1 | 0 = mean band, 1 = per-cell limits |
| nom_i | input | VW | Nominal voltage for mean mode |
| pct_i | input | PCT_W | Band half-width in whole percent |
| cell_lo_i | input | VW | Lower cell limit for cell mode |
| cell_hi_i | input | VW | Upper cell limit for cell mode |
| done_o | output | 1 | One-cycle pulse: new results are present |
| avg_o | output | VW | Mean of the latest period |
| min_o | output | VW | Smallest sample of the latest period |
| max_o | output | VW | Largest sample of the latest period |
| oob_o | output | 1 | Out of band: re-sort and reset the kept states |
| under_o | output | 1 | Mean below the band in mean mode |

## Verification
Every result (the mean, the extremes, both flags and the done pulse) becomes visible one clock after the edge that takes the beat marked last. Intermediate beats change no output. The bench drives inputs on falling edges and reads the results on the first falling edge after the last beat. One edge later it checks that done_o has dropped and that the statistics have not moved. Periods with idle gaps, and settings that change after the first beat, shift nothing in this timing. The bench therefore computes every expected value once per period, from the samples it sent and the settings it applied on the first beat.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  typedef enum logic {MODE_AVG = 1'b0, MODE_CELL = 1'b1} band_mode_e;

  localparam int unsigned FRAC   = 16;
  localparam int unsigned RCP100 = 655;  // floor(2^16 / 100)

  function automatic int unsigned rcp_of(input int unsigned n);
    return ((32'd1 << FRAC) + n - 1) / n;
  endfunction
endpackage

// File: rtl/tbm_accum.sv
module tbm_accum #(
  parameter int unsigned VW    = 16,
  parameter int unsigned SUM_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             last_i,
  input  logic [VW-1:0]    v_i,
  output logic             first_o,
  output logic [SUM_W-1:0] sum_nx_o,
  output logic [VW-1:0]    min_nx_o,
  output logic [VW-1:0]    max_nx_o
);
  logic             busy_q;
  logic [SUM_W-1:0] acc_q;
  logic [VW-1:0]    min_q, max_q;

  assign first_o = !busy_q;

  always_comb begin
    sum_nx_o = (busy_q ? acc_q : '0) + SUM_W'(v_i);
    min_nx_o = (!busy_q || v_i < min_q) ? v_i : min_q;
    max_nx_o = (!busy_q || v_i > max_q) ? v_i : max_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      acc_q  <= '0;
      min_q  <= '0;
      max_q  <= '0;
    end else if (vld_i) begin
      busy_q <= !last_i;
      acc_q  <= sum_nx_o;
      min_q  <= min_nx_o;
      max_q  <= max_nx_o;
    end
  end
endmodule

// File: rtl/tbm_limits.sv
module tbm_limits
  import tbm_pkg::*;
#(
  parameter int unsigned VW    = 16,
  parameter int unsigned PCT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  band_mode_e       mode_i,
  input  logic [VW-1:0]    nom_i,
  input  logic [PCT_W-1:0] pct_i,
  input  logic [VW-1:0]    clo_i,
  input  logic [VW-1:0]    chi_i,
  output band_mode_e       mode_o,
  output logic [VW:0]      lo_o,
  output logic [VW:0]      hi_o
);
  localparam int unsigned PW = VW + PCT_W + 11;
  localparam logic [VW:0] LIM_MAX = '1;

  band_mode_e       mode_q;
  logic [VW-1:0]    nom_q, clo_q, chi_q;
  logic [PCT_W-1:0] pct_q;

  // first beat uses live settings so a one-beat period still works
  band_mode_e       mode_s;
  logic [VW-1:0]    nom_s, clo_s, chi_s;
  logic [PCT_W-1:0] pct_s;
  logic [PW-1:0]    prod, dl, hsum;

  always_comb begin
    mode_s = cap_i ? mode_i : mode_q;
    nom_s  = cap_i ? nom_i  : nom_q;
    pct_s  = cap_i ? pct_i  : pct_q;
    clo_s  = cap_i ? clo_i  : clo_q;
    chi_s  = cap_i ? chi_i  : chi_q;
    prod   = PW'(nom_s) * PW'(pct_s) * PW'(RCP100);
    dl     = prod >> FRAC;
    hsum   = PW'(nom_s) + dl;
    mode_o = mode_s;
    if (mode_s == MODE_CELL) begin
      lo_o = {1'b0, clo_s};
      hi_o = {1'b0, chi_s};
    end else begin
      lo_o = (dl >= PW'(nom_s)) ? '0 : (VW+1)'(PW'(nom_s) - dl);
      hi_o = (hsum > PW'(LIM_MAX)) ? LIM_MAX : hsum[VW:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_AVG;
      nom_q  <= '0;
      pct_q  <= '0;
      clo_q  <= '0;
      chi_q  <= '0;
    end else if (cap_i) begin
      mode_q <= mode_i;
      nom_q  <= nom_i;
      pct_q  <= pct_i;
      clo_q  <= clo_i;
      chi_q  <= chi_i;
    end
  end
endmodule

// File: rtl/tbm_judge.sv
module tbm_judge
  import tbm_pkg::*;
#(
  parameter int unsigned VW      = 16,
  parameter int unsigned SUM_W   = 20,
  parameter int unsigned N_CELLS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             end_i,
  input  band_mode_e       mode_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [VW-1:0]    min_i,
  input  logic [VW-1:0]    max_i,
  input  logic [VW:0]      lo_i,
  input  logic [VW:0]      hi_i,
  output logic             done_o,
  output logic [VW-1:0]    avg_o,
  output logic [VW-1:0]    min_o,
  output logic [VW-1:0]    max_o,
  output logic             oob_o,
  output logic             under_o
);
  localparam int unsigned RCP_N = rcp_of(N_CELLS);
  localparam int unsigned MW    = SUM_W + FRAC + 2;

  logic [MW-1:0] mul, quo;
  logic [VW-1:0] avg_c;
  logic [VW:0]   avg_x, min_x, max_x;
  logic          oob_c, under_c;

  always_comb begin
    mul   = MW'(sum_i) * MW'(RCP_N);
    quo   = mul >> FRAC;
    avg_c = (quo > MW'({VW{1'b1}})) ? '1 : quo[VW-1:0];
    avg_x = {1'b0, avg_c};
    min_x = {1'b0, min_i};
    max_x = {1'b0, max_i};
    if (mode_i == MODE_CELL) begin
      oob_c   = !((lo_i < min_x) && (max_x < hi_i));
      under_c = 1'b0;
    end else begin
      oob_c   = !((lo_i < avg_x) && (avg_x < hi_i));
      under_c = avg_x < lo_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      avg_o   <= '0;
      min_o   <= '0;
      max_o   <= '0;
      oob_o   <= 1'b0;
      under_o <= 1'b0;
    end else begin
      done_o <= end_i;
      if (end_i) begin
        avg_o   <= avg_c;
        min_o   <= min_i;
        max_o   <= max_i;
        oob_o   <= oob_c;
        under_o <= under_c;
      end
    end
  end
endmodule

// File: rtl/tol_band_mon.sv
module tol_band_mon
  import tbm_pkg::*;
#(
  parameter int unsigned VW      = 16,
  parameter int unsigned N_CELLS = 8,
  parameter int unsigned PCT_W   = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             last_i,
  input  logic [VW-1:0]    volt_i,
  input  logic             mode_i,
  input  logic [VW-1:0]    nom_i,
  input  logic [PCT_W-1:0] pct_i,
  input  logic [VW-1:0]    cell_lo_i,
  input  logic [VW-1:0]    cell_hi_i,
  output logic             done_o,
  output logic [VW-1:0]    avg_o,
  output logic [VW-1:0]    min_o,
  output logic [VW-1:0]    max_o,
  output logic             oob_o,
  output logic             under_o
);
  localparam int unsigned SUM_W = VW + $clog2(N_CELLS + 1);

  logic             first;
  logic [SUM_W-1:0] sum_nx;
  logic [VW-1:0]    min_nx, max_nx;
  band_mode_e       mode_s;
  logic [VW:0]      lo, hi;

  tbm_accum #(.VW(VW), .SUM_W(SUM_W)) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i), .last_i(last_i), .v_i(volt_i),
    .first_o(first), .sum_nx_o(sum_nx), .min_nx_o(min_nx), .max_nx_o(max_nx)
  );

  tbm_limits #(.VW(VW), .PCT_W(PCT_W)) u_limits (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(vld_i && first),
    .mode_i(band_mode_e'(mode_i)), .nom_i(nom_i), .pct_i(pct_i),
    .clo_i(cell_lo_i), .chi_i(cell_hi_i),
    .mode_o(mode_s), .lo_o(lo), .hi_o(hi)
  );

  tbm_judge #(.VW(VW), .SUM_W(SUM_W), .N_CELLS(N_CELLS)) u_judge (
    .clk_i(clk_i), .rst_ni(rst_ni), .end_i(vld_i && last_i), .mode_i(mode_s),
    .sum_i(sum_nx), .min_i(min_nx), .max_i(max_nx), .lo_i(lo), .hi_i(hi),
    .done_o(done_o), .avg_o(avg_o), .min_o(min_o), .max_o(max_o),
    .oob_o(oob_o), .under_o(under_o)
  );
endmodule

// File: rtl/tbm_checks.sv
module tbm_checks #(
  parameter int unsigned VW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          vld_i,
  input logic          last_i,
  input logic          done_o,
  input logic [VW-1:0] avg_o,
  input logic [VW-1:0] min_o,
  input logic [VW-1:0] max_o,
  input logic          oob_o,
  input logic          under_o
);
  p_done_after_last_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && last_i |=> done_o);

  p_avg_ge_min_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> avg_o >= min_o);

  p_min_le_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> min_o <= max_o);

  p_under_is_oob_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    under_o |-> oob_o);

  p_done_needs_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(vld_i && last_i));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({avg_o, min_o, max_o, oob_o, under_o}));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r9: assert (!done_o && !oob_o && !under_o && avg_o == '0);
    end
  end
endmodule

bind tol_band_mon tbm_checks #(.VW(VW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i), .last_i(last_i),
  .done_o(done_o), .avg_o(avg_o), .min_o(min_o), .max_o(max_o),
  .oob_o(oob_o), .under_o(under_o)
);

// File: tb/sim_tol_band_mon.sv
module sim_tol_band_mon;
  localparam int NC = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vld_i = 1'b0, last_i = 1'b0, mode_i = 1'b0;
  logic [15:0] volt_i = '0, nom_i = '0, cell_lo_i = '0, cell_hi_i = '0;
  logic [6:0]  pct_i = '0;
  logic        done_o, oob_o, under_o;
  logic [15:0] avg_o, min_o, max_o;

  int total = 0, bad = 0;
  int cur_v [NC];

  always #10 clk = ~clk;

  tol_band_mon u0 (
    .clk_i(clk), .rst_ni(rst_ni), .vld_i(vld_i), .last_i(last_i), .volt_i(volt_i),
    .mode_i(mode_i), .nom_i(nom_i), .pct_i(pct_i), .cell_lo_i(cell_lo_i),
    .cell_hi_i(cell_hi_i), .done_o(done_o), .avg_o(avg_o), .min_o(min_o),
    .max_o(max_o), .oob_o(oob_o), .under_o(under_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_avg(input longint s);
    longint k = (65536 + NC - 1) / NC;
    longint a = (s * k) >> 16;
    return (a > 65535) ? 65535 : a;
  endfunction

  task automatic run_period(input bit md, input int nom, input int pct, input int clo,
                            input int chi, input bit scramble, input bit gaps,
                            input string tag);
    longint s = 0, mn = 65535, mx = 0, a, d, lo, hi, pa, pmn, pmx;
    bit eo, eu;
    mode_i = md; nom_i = 16'(nom); pct_i = 7'(pct);
    cell_lo_i = 16'(clo); cell_hi_i = 16'(chi);
    for (int k = 0; k < NC; k++) begin
      @(negedge clk);
      vld_i = 1'b1; volt_i = 16'(cur_v[k]); last_i = (k == NC - 1);
      if (scramble && k == 1) begin  // R7: late setting changes
        mode_i = ~md; nom_i = 16'd900; pct_i = 7'd50;
        cell_lo_i = 16'd0; cell_hi_i = 16'hFFFF;
      end
      if (gaps && k < NC - 1) begin
        @(negedge clk);
        vld_i = 1'b0; volt_i = 16'hFFFF; last_i = 1'b0;
      end
      s += cur_v[k];
      if (cur_v[k] < mn) mn = cur_v[k];
      if (cur_v[k] > mx) mx = cur_v[k];
    end
    @(negedge clk);
    vld_i = 1'b0; last_i = 1'b0;
    a  = exp_avg(s);
    d  = (longint'(nom) * pct * 655) >> 16;
    lo = (d >= nom) ? 0 : nom - d;
    hi = (nom + d > 131071) ? 131071 : nom + d;
    if (md) begin
      eo = !((clo < mn) && (mx < chi)); eu = 1'b0;
    end else begin
      eo = !((lo < a) && (a < hi)); eu = (a < lo);
    end
    chk(done_o == 1'b1, "R1", {tag, " done"}, done_o, 1);
    chk(avg_o == a, "R1", {tag, " avg"}, avg_o, a);
    chk(min_o == mn, "R2", {tag, " min"}, min_o, mn);
    chk(max_o == mx, "R2", {tag, " max"}, max_o, mx);
    chk(oob_o == eo, md ? "R5" : "R3", {tag, " oob"}, oob_o, eo);
    chk(under_o == eu, "R6", {tag, " under"}, under_o, eu);
    pa = avg_o; pmn = min_o; pmx = max_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R8", {tag, " done drop"}, done_o, 0);
    chk(avg_o == pa && min_o == pmn && max_o == pmx, "R8", {tag, " hold"}, avg_o, pa);
  endtask

  task automatic fill(input int v);
    for (int k = 0; k < NC; k++) cur_v[k] = v;
  endtask

  task automatic tests;
    void'($urandom(32'd1234));
    #5;
    chk(done_o == 0 && avg_o == 0 && min_o == 0 && max_o == 0, "R9", "reset stats", avg_o, 0);
    chk(oob_o == 0 && under_o == 0, "R9", "reset flags", oob_o, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R3: centre and both edges of a 4 % band (L=2305, H=2495)
    fill(2400); run_period(0, 2400, 4, 0, 0, 0, 0, "R3 centre");
    fill(2494); run_period(0, 2400, 4, 0, 0, 0, 0, "R3 below hi");
    fill(2495); run_period(0, 2400, 4, 0, 0, 0, 0, "R3 at hi");
    fill(2306); run_period(0, 2400, 4, 0, 0, 0, 0, "R3 above lo");
    fill(2305); run_period(0, 2400, 4, 0, 0, 0, 0, "R6 at lo");
    fill(2304); run_period(0, 2400, 4, 0, 0, 0, 0, "R6 below lo");
    // R4: zero width
    fill(2400); run_period(0, 2400, 0, 0, 0, 0, 0, "R4 pct0");
    fill(2300); run_period(1, 0, 0, 2200, 2200, 0, 0, "R4 cell equal");
    // R5 / R6 cell mode
    for (int k = 0; k < NC; k++) cur_v[k] = 2101 + k * 50;
    run_period(1, 0, 0, 2100, 2500, 0, 0, "R5 inside");
    cur_v[3] = 2500; run_period(1, 0, 0, 2100, 2500, 0, 0, "R5 max at hi");
    cur_v[3] = 1000; run_period(1, 0, 0, 2100, 2500, 0, 0, "R6 cell low min");
    // R2: extremes restart; R1: gaps
    fill(3000); cur_v[5] = 3900; run_period(0, 2400, 8, 0, 0, 0, 1, "R2 high period");
    fill(1500); cur_v[2] = 1400; run_period(0, 2400, 8, 0, 0, 0, 1, "R2 low period");
    // R7: settings changed after first beat
    fill(2400); run_period(0, 2400, 4, 0, 0, 1, 0, "R7 mean");
    fill(2400); run_period(1, 0, 0, 2300, 2350, 1, 0, "R7 cell");
    // R3 saturation of the lower limit
    fill(10); run_period(0, 100, 120, 0, 0, 0, 0, "R3 lo clamp");
    for (int n = 0; n < 40; n++) begin
      int pl [5] = '{0, 3, 4, 6, 8};
      int clo;
      for (int k = 0; k < NC; k++) cur_v[k] = 2300 + int'($urandom % 201);
      clo = 2200 + int'($urandom % 150);
      run_period(1'($urandom % 2), 2400, pl[$urandom % 5], clo, clo + int'($urandom % 400),
                 1'($urandom % 2), 1'($urandom % 2), "rand");
    end
  endtask

  initial begin
    fork
      tests();
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule